// File: doc/BRIEF.md
# Peripheral Protection Gatekeeper

The gatekeeper sits between one APB4 requester and sixteen downstream peripheral ports. Address decode logic outside the block picks the target port for each transfer by raising one bit of a select vector. The block compares the transfer's protection attributes on `up_pprot` with two configuration inputs for that port. The first input states whether the port serves secure or non-secure traffic. The second states whether unprivileged traffic may reach it. An accepted transfer reaches the selected port with its address, data and attributes unchanged, and the port's response returns to the requester.

A refused transfer never reaches any port. The requester still receives a response in the first access cycle. Depending on `err_mode`, that response is either an error, or a read that returns zero and a write that is discarded. Every refusal sets a sticky pending flag. The interrupt output shows that flag when `irq_en` is high, and `irq_clr` clears it. An elaboration-time mask exempts chosen ports from the security check, so that only the privilege check applies to them. All configuration arrives on plain input wires; the block has no registers that software can reach.

The control is a three-state machine:
- **ST_IDLE** waits for a setup phase.
- The transition **GRANT** (setup phase, and the check passes) leads to **ST_PASS**, where the transfer is forwarded.
- The transition **REFUSE** (setup phase, and the check fails) leads to **ST_BLOCK**, where a local response is given.
- The transition **DONE** returns to ST_IDLE. From ST_PASS it fires on the access cycle in which the port raises ready. From ST_BLOCK it fires on the first access cycle.

Top module: `periph_guard`

## Requirements
- R1: A transfer that passes the check drives `dn_psel` equal to `port_sel` in the setup cycle, and sets `dn_penable` in the access phase. The selected port's `dn_prdata`, `dn_pready` and `dn_pslverr` appear on the upstream response, and the port stores the write data on a write.
- R2: The security check applies to a port whose mask bit is clear, and the security attribute is `up_pprot[1]` (1 = non-secure). The check passes only when `up_pprot[1]` equals `allow_ns[n]`. A non-secure transfer to a port with `allow_ns[n]`=0 is refused. A secure transfer to a port with `allow_ns[n]`=1 is also refused.
- R3: The privilege attribute is `up_pprot[0]` (1 = privileged). An unprivileged transfer to a port with `allow_user[n]`=0 is refused. A privileged transfer always passes the privilege check.
- R4: For a port whose bit in parameter `NS_EXEMPT` is set, secure and non-secure transfers both pass the security check, and only the privilege check applies.
- R5: A refused transfer raises no bit of `dn_psel` and does not raise `dn_penable`, in any cycle of that transfer.
- R6: A refused transfer completes in its first access cycle with `up_pready`=1 and `up_prdata`=0. `up_pslverr` equals the value of `err_mode` sampled in the setup cycle. When that value is 0, a refused write leaves the port's stored data unchanged.
- R7: A transfer with no bit of `port_sel` set, or with more than one bit set, is refused.
- R8: A refusal in the setup cycle sets the pending flag on the next clock edge. The flag then stays set until it is cleared. `irq` is the pending flag ANDed with `irq_en`.
- R9: While `irq_clr` is high, the pending flag is clear from the next edge on, and it stays clear even if transfers are refused. A refusal in the cycle where `irq_clr` has just returned low sets the flag on the next edge.
- R10: After reset the state is ST_IDLE, `irq`=0, `up_pready`=0 and `dn_psel`=0. Every transfer returns to ST_IDLE at DONE, so a new setup phase may follow immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_psel | input | 1 | Upstream select |
| up_penable | input | 1 | Upstream enable (access phase) |
| up_pwrite | input | 1 | Upstream write strobe |
| up_paddr | input | AW | Upstream address |
| up_pwdata | input | DW | Upstream write data |
| up_pprot | input | 3 | Protection attributes: [0] privileged, [1] non-secure |
| up_prdata | output | DW | Upstream read data |
| up_pready | output | 1 | Upstream ready |
| up_pslverr | output | 1 | Upstream error response |
| port_sel | input | N | One-hot port select from external decode |
| allow_ns | input | N | Per port: 1 = non-secure port, 0 = secure port |
| allow_user | input | N | Per port: 1 = unprivileged traffic allowed |
| err_mode | input | 1 | 1 = refuse with error, 0 = read zero / write ignored |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear the pending refusal flag |
| irq | output | 1 | Refusal interrupt |
| dn_psel | output | N | Per-port downstream select |
| dn_penable | output | 1 | Downstream enable |
| dn_pwrite | output | 1 | Downstream write strobe |
| dn_paddr | output | AW | Downstream address |
| dn_pwdata | output | DW | Downstream write data |
| dn_pprot | output | 3 | Downstream protection attributes |
| dn_prdata | input | N*DW | Per-port read data, packed by port |
| dn_pready | input | N | Per-port ready |
| dn_pslverr | input | N | Per-port error response |

## Verification
A state machine that latched the wrong verdict shows one of two symptoms in the setup or first access cycle. Either a downstream select rises for a refused transfer, or a permitted transfer receives a zero or error response instead of the port's data. The bench therefore compares the downstream selects in the setup cycle and the response in the access cycle of every transfer. A wrong held port index shows in the same access cycle, as read data from the wrong port. A pending flag that set late, failed to stick, or ignored the clear shows on `irq` one cycle after the setup of a refused transfer. A write-ignored refusal that actually reached a port is exposed when the same port is read back later.

// File: rtl/guard_pkg.sv
package guard_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_BLOCK = 2'd2
    } gstate_t;
endpackage

// File: rtl/guard_rules.sv
module guard_rules #(
    parameter int          N         = 16,
    parameter logic [N-1:0] NS_EXEMPT = '0
) (
    input  logic [N-1:0] port_sel,
    input  logic [1:0]   attr,
    input  logic [N-1:0] allow_ns,
    input  logic [N-1:0] allow_user,
    output logic         sel_ok,
    output logic         grant
);
    logic [N-1:0] port_ok;

    for (genvar n = 0; n < N; n++) begin : g_port
        logic sec_pass;
        logic priv_pass;
        if (NS_EXEMPT[n]) begin : g_exempt
            assign sec_pass = 1'b1;
        end else begin : g_checked
            assign sec_pass = (attr[1] == allow_ns[n]);
        end
        assign priv_pass  = attr[0] | allow_user[n];
        assign port_ok[n] = sec_pass & priv_pass;
    end

    assign sel_ok = $onehot(port_sel);
    assign grant  = sel_ok & (|(port_sel & port_ok));
endmodule

// File: rtl/guard_irq.sv
module guard_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic refuse,
    input  logic clr,
    input  logic en,
    output logic pending,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (clr) begin
            pending <= 1'b0;
        end else if (refuse) begin
            pending <= 1'b1;
        end
    end

    assign irq = pending & en;
endmodule

// File: rtl/guard_resp_mux.sv
module guard_resp_mux #(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input  logic [N-1:0]         held_sel,
    input  logic [N-1:0][DW-1:0] dn_prdata,
    input  logic [N-1:0]         dn_pready,
    input  logic [N-1:0]         dn_pslverr,
    output logic [DW-1:0]        rdata,
    output logic                 ready,
    output logic                 slverr
);
    always_comb begin
        rdata  = '0;
        ready  = 1'b0;
        slverr = 1'b0;
        for (int n = 0; n < N; n++) begin
            if (held_sel[n]) begin
                rdata  = rdata | dn_prdata[n];
                ready  = ready | dn_pready[n];
                slverr = slverr | dn_pslverr[n];
            end
        end
    end
endmodule

// File: rtl/periph_guard.sv
module periph_guard #(
    parameter int           N         = 16,
    parameter int           AW        = 12,
    parameter int           DW        = 32,
    parameter logic [N-1:0] NS_EXEMPT = 16'h8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_psel,
    input  logic                 up_penable,
    input  logic                 up_pwrite,
    input  logic [AW-1:0]        up_paddr,
    input  logic [DW-1:0]        up_pwdata,
    input  logic [2:0]           up_pprot,
    output logic [DW-1:0]        up_prdata,
    output logic                 up_pready,
    output logic                 up_pslverr,
    input  logic [N-1:0]         port_sel,
    input  logic [N-1:0]         allow_ns,
    input  logic [N-1:0]         allow_user,
    input  logic                 err_mode,
    input  logic                 irq_en,
    input  logic                 irq_clr,
    output logic                 irq,
    output logic [N-1:0]         dn_psel,
    output logic                 dn_penable,
    output logic                 dn_pwrite,
    output logic [AW-1:0]        dn_paddr,
    output logic [DW-1:0]        dn_pwdata,
    output logic [2:0]           dn_pprot,
    input  logic [N-1:0][DW-1:0] dn_prdata,
    input  logic [N-1:0]         dn_pready,
    input  logic [N-1:0]         dn_pslverr
);
    import guard_pkg::*;

    gstate_t      state_q, state_d;
    logic [N-1:0] held_sel_q;
    logic         err_q;
    logic         sel_ok;
    logic         grant;
    logic         setup;
    logic         refuse;
    logic         pending;
    logic [DW-1:0] mux_rdata;
    logic          mux_ready;
    logic          mux_slverr;

    guard_rules #(.N(N), .NS_EXEMPT(NS_EXEMPT)) u_rules (
        .port_sel   (port_sel),
        .attr       (up_pprot[1:0]),
        .allow_ns   (allow_ns),
        .allow_user (allow_user),
        .sel_ok     (sel_ok),
        .grant      (grant)
    );

    guard_resp_mux #(.N(N), .DW(DW)) u_mux (
        .held_sel   (held_sel_q),
        .dn_prdata  (dn_prdata),
        .dn_pready  (dn_pready),
        .dn_pslverr (dn_pslverr),
        .rdata      (mux_rdata),
        .ready      (mux_ready),
        .slverr     (mux_slverr)
    );

    assign setup  = up_psel & ~up_penable & (state_q == ST_IDLE);
    assign refuse = setup & ~grant;

    guard_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .refuse  (refuse),
        .clr     (irq_clr),
        .en      (irq_en),
        .pending (pending),
        .irq     (irq)
    );

    // next-state logic: GRANT, REFUSE, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (setup) state_d = grant ? ST_PASS : ST_BLOCK;
            end
            ST_PASS: begin
                if (up_psel && up_penable && mux_ready) state_d = ST_IDLE;
            end
            ST_BLOCK: begin
                if (up_psel && up_penable) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            held_sel_q <= '0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (setup) begin
                held_sel_q <= grant ? port_sel : '0;
                err_q      <= err_mode;
            end
        end
    end

    // outputs
    assign dn_pwrite = up_pwrite;
    assign dn_paddr  = up_paddr;
    assign dn_pwdata = up_pwdata;
    assign dn_pprot  = up_pprot;

    always_comb begin
        dn_psel    = '0;
        dn_penable = 1'b0;
        up_prdata  = '0;
        up_pready  = 1'b0;
        up_pslverr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (setup && grant) dn_psel = port_sel;
            end
            ST_PASS: begin
                dn_psel    = held_sel_q & {N{up_psel}};
                dn_penable = up_penable;
                up_prdata  = mux_rdata;
                up_pready  = mux_ready;
                up_pslverr = mux_slverr & mux_ready;
            end
            ST_BLOCK: begin
                up_pready  = 1'b1;
                up_pslverr = err_q;
            end
            default: begin
                dn_psel = '0;
            end
        endcase
    end

    logic unused_ok;
    assign unused_ok = sel_ok;
endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input guard_pkg::gstate_t state_q,
    input logic              up_psel,
    input logic              up_penable,
    input logic [N-1:0]      port_sel,
    input logic [DW-1:0]     up_prdata,
    input logic              up_pready,
    input logic [N-1:0]      dn_psel,
    input logic              dn_penable,
    input logic              pending,
    input logic              irq_en,
    input logic              irq_clr,
    input logic              irq
);
    import guard_pkg::*;

    assert_block_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK) |-> (dn_psel == '0 && !dn_penable));

    assert_psel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_psel));

    assert_block_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK && up_psel && up_penable) |-> (up_pready && up_prdata == '0));

    assert_bad_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && up_psel && !up_penable && !$onehot(port_sel)) |=> (state_q == ST_BLOCK));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !irq_clr) |=> pending);

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !pending);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK && up_psel && up_penable) |=> (state_q == ST_IDLE));
endmodule

bind periph_guard guard_checker #(.N(N), .DW(DW)) u_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .up_psel    (up_psel),
    .up_penable (up_penable),
    .port_sel   (port_sel),
    .up_prdata  (up_prdata),
    .up_pready  (up_pready),
    .dn_psel    (dn_psel),
    .dn_penable (dn_penable),
    .pending    (pending),
    .irq_en     (irq_en),
    .irq_clr    (irq_clr),
    .irq        (irq)
);

// File: tb/periph_guard_bench.sv
module periph_guard_bench;
    localparam int          N      = 16;
    localparam int          AW     = 12;
    localparam int          DW     = 32;
    localparam logic [15:0] EXEMPT = 16'h8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                 up_psel = 0, up_penable = 0, up_pwrite = 0;
    logic [AW-1:0]        up_paddr = '0;
    logic [DW-1:0]        up_pwdata = '0;
    logic [2:0]           up_pprot = '0;
    logic [DW-1:0]        up_prdata;
    logic                 up_pready, up_pslverr;
    logic [N-1:0]         port_sel = '0, allow_ns = '0, allow_user = '0;
    logic                 err_mode = 1, irq_en = 0, irq_clr = 0;
    logic                 irq;
    logic [N-1:0]         dn_psel;
    logic                 dn_penable, dn_pwrite;
    logic [AW-1:0]        dn_paddr;
    logic [DW-1:0]        dn_pwdata;
    logic [2:0]           dn_pprot;
    logic [N-1:0][DW-1:0] dn_prdata;
    logic [N-1:0]         dn_pready, dn_pslverr;

    periph_guard #(.N(N), .AW(AW), .DW(DW), .NS_EXEMPT(EXEMPT)) u_periph_guard (.*);

    // downstream peripherals: one word each, port 5 always answers with error
    logic [N-1:0][DW-1:0] mem;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < N; n++) mem[n] <= 32'h1000_0000 + n;
        end else begin
            for (int n = 0; n < N; n++)
                if (dn_psel[n] && dn_penable && dn_pwrite) mem[n] <= dn_pwdata;
        end
    end
    always_comb begin
        for (int n = 0; n < N; n++) begin
            dn_prdata[n]  = mem[n];
            dn_pready[n]  = 1'b1;
            dn_pslverr[n] = (n == 5);
        end
    end

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] refmem [N];

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct { logic wr; logic [DW-1:0] rdata; logic err; string req; } item_t;
    item_t sb [$];

    // monitor: compares each completed upstream transfer
    always @(negedge clk) begin
        #1;
        if (up_psel && up_penable && up_pready) begin
            if (sb.size() == 0) begin
                check("R10 unexpected completion", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check({it.req, " pslverr"}, up_pslverr, it.err);
                if (!it.wr) check({it.req, " prdata"}, up_prdata, it.rdata);
            end
        end
    end

    function automatic logic expect_pass(input logic [N-1:0] sel, input logic [2:0] prot);
        int p;
        if ($countones(sel) != 1) return 1'b0;
        p = 0;
        for (int n = 0; n < N; n++) if (sel[n]) p = n;
        return (EXEMPT[p] || (prot[1] == allow_ns[p])) && (prot[0] || allow_user[p]);
    endfunction

    // driver: one APB transfer; exp_irq < 0 skips the access-cycle irq check
    task automatic xfer(input string req, input logic [N-1:0] sel, input logic [2:0] prot,
                        input logic wr, input logic [DW-1:0] wd,
                        input int exp_irq, input int clr_at_setup);
        item_t it;
        logic  ok;
        int    p;
        ok = expect_pass(sel, prot);
        p = 0;
        for (int n = 0; n < N; n++) if (sel[n]) p = n;
        it.wr = wr;
        it.req = req;
        it.rdata = ok ? refmem[p] : '0;
        it.err = ok ? (p == 5) : err_mode;
        sb.push_back(it);
        @(negedge clk);
        up_psel = 1; up_penable = 0; up_pwrite = wr; up_pwdata = wd;
        up_paddr = AW'(p * 4); up_pprot = prot; port_sel = sel;
        if (clr_at_setup >= 0) irq_clr = clr_at_setup[0];
        #1;
        check({req, " dn_psel setup (R1/R5)"}, DW'(dn_psel), ok ? DW'(sel) : '0);
        @(negedge clk);
        up_penable = 1;
        #1;
        check({req, " dn_penable access (R1/R5)"}, DW'(dn_penable), DW'(ok));
        if (exp_irq >= 0) check({req, " irq after setup (R8/R9)"}, DW'(irq), DW'(exp_irq));
        while (!up_pready) begin
            @(negedge clk);
            #1;
        end
        if (ok && wr) refmem[p] = wd;
        @(negedge clk);
        up_psel = 0; up_penable = 0; port_sel = '0;
    endtask

    localparam logic [2:0] S_PRIV = 3'b001, NS_PRIV = 3'b011, S_USER = 3'b000, NS_USER = 3'b010;

    initial begin
        for (int n = 0; n < N; n++) refmem[n] = 32'h1000_0000 + n;
        allow_ns   = 16'h00F0;
        allow_user = 16'h0F0F;
        #1;
        // R10: reset state
        check("R10 irq at reset", DW'(irq), 0);
        check("R10 pready at reset", DW'(up_pready), 0);
        check("R10 dn_psel at reset", DW'(dn_psel), 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;

        xfer("R1 secure read port0", 16'h0001, S_PRIV, 0, 0, -1, -1);
        xfer("R1 write port1", 16'h0002, S_PRIV, 1, 32'hCAFE_0001, -1, -1);
        xfer("R1 readback port1", 16'h0002, S_PRIV, 0, 0, -1, -1);
        xfer("R1 error pass-through port5", 16'h0020, NS_PRIV, 0, 0, -1, -1);
        xfer("R2 non-secure to secure port", 16'h0001, NS_PRIV, 0, 0, -1, -1);
        xfer("R2 secure to non-secure port", 16'h0010, S_PRIV, 0, 0, -1, -1);
        xfer("R2 non-secure to non-secure port", 16'h0010, NS_PRIV, 0, 0, -1, -1);
        xfer("R3 user to user-denied port", 16'h0010, NS_USER, 0, 0, -1, -1);
        xfer("R3 user to user-allowed port", 16'h0001, S_USER, 0, 0, -1, -1);
        xfer("R4 exempt port secure", 16'h8000, S_PRIV, 0, 0, -1, -1);
        xfer("R4 exempt port non-secure", 16'h8000, NS_PRIV, 1, 32'h0BAD_F00D, -1, -1);
        xfer("R4 exempt port user denied", 16'h8000, NS_USER, 0, 0, -1, -1);
        xfer("R7 no select", 16'h0000, S_PRIV, 0, 0, -1, -1);
        xfer("R7 two selects", 16'h0003, S_PRIV, 0, 0, -1, -1);

        // R6: read-as-zero / write-ignored mode
        err_mode = 0;
        xfer("R6 ignored write port1", 16'h0002, NS_PRIV, 1, 32'hDEAD_BEEF, -1, -1);
        xfer("R6 port1 unchanged", 16'h0002, S_PRIV, 0, 0, -1, -1);
        xfer("R6 raz read", 16'h0004, NS_PRIV, 0, 0, -1, -1);
        err_mode = 1;

        // R8: pending sets one edge after refusal setup, gated by irq_en
        irq_clr = 1; irq_en = 1;
        @(negedge clk);
        irq_clr = 0;
        #1;
        check("R8 irq clear before test", DW'(irq), 0);
        xfer("R8 refusal sets irq", 16'h0001, NS_PRIV, 0, 0, 1, -1);
        xfer("R8 sticky over pass", 16'h0001, S_PRIV, 0, 0, 1, -1);
        irq_en = 0;
        #1;
        check("R8 gated off", DW'(irq), 0);
        irq_en = 1;
        #1;
        check("R8 still pending", DW'(irq), 1);

        // R9: clear held high wins over refusals
        @(negedge clk);
        irq_clr = 1;
        xfer("R9 refusal while clear held", 16'h0001, NS_PRIV, 0, 0, 0, -1);
        @(negedge clk);
        #1;
        check("R9 stays clear", DW'(irq), 0);
        xfer("R9 clear released at setup", 16'h0001, NS_PRIV, 0, 0, 1, 0);

        // R10: back-to-back completion returns to idle
        xfer("R10 back-to-back A", 16'h0001, S_PRIV, 0, 0, -1, -1);
        xfer("R10 back-to-back B", 16'h0010, NS_PRIV, 0, 0, -1, -1);

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", DW'(sb.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule